// File: doc/BRIEF.md
# Two-Bit Branch Target Predictor

This block predicts, at instruction fetch, whether a control-transfer instruction will redirect the program and where it will go. It keeps a direct-mapped table of 128 entries selected by bits of the fetch address. Each entry holds a valid flag, an address tag, a stored target and a two-bit saturating confidence counter. Conditional branches and unconditional jump-and-link instructions are handled the same way.

The fetch stage presents a program counter on the lookup port and gets the prediction back in the same cycle with no register in the path. When a branch or jump resolves in the execute stage, that stage drives the update port for one cycle with the resolved address, the instruction kind, the real direction and the real target. The block does not recover from mispredictions. That belongs to the pipeline.

Both ports are plain control ports with no back-pressure. A lookup is served in every cycle. An update is taken on every rising clock edge where `upd_valid` is high. The block never stalls either side, so it has no ready signals.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so any lookup predicts not-taken with `lk_pc + 4` as the target.
- R2: The entry index is `pc[8:2]` and the tag is `pc[31:9]`. Bits `pc[1:0]` play no part in selecting or matching an entry.
- R3: An update whose index holds no valid entry, or holds one with a different tag, installs the entry. The new tag and target are written, and the counter starts at 2 if the outcome was taken or at 1 if it was not.
- R4: A lookup predicts taken only when the entry is valid, the tag matches and the counter is 2 or 3. The target is then the stored target. In every other case the target is `lk_pc + 4`.
- R5: A taken update to a matching entry increments the counter and holds it at 3.
- R6: A not-taken update to a matching entry decrements the counter and holds it at 0.
- R7: An update whose tag differs from a valid entry at the same index replaces that entry, and lookups of the old address then miss.
- R8: A lookup in the same cycle as an update to the same entry returns the contents from before the update.
- R9: An update marked as a jump (`upd_is_jump` = 1) is treated as taken whatever `upd_taken` says.
- R10: A not-taken update to a matching entry keeps the stored target. A taken update overwrites it with `upd_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Predicted redirect |
| pred_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved outcome present this cycle |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_is_jump | input | 1 | 1 = jump-and-link, 0 = conditional branch |
| upd_taken | input | 1 | Actual direction of a conditional branch |
| upd_target | input | 32 | Actual destination address |

## Verification
The assertions assume that reset is held for at least one clock before any update. They also assume that `upd_valid` and the update fields are known, not X or Z, on every edge after reset. The bench holds reset for several cycles and drives every update field with defined values on every cycle, including cycles where `upd_valid` is low. Random addresses come from a small pool of indexes and two tags. This pool makes hits, aliasing replacements, counter saturation at both ends and same-cycle lookup/update collisions happen often, without leaving the defined input range.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN     = 2'd0;
  localparam ctr_t CTR_WEAK_NT = 2'd1;
  localparam ctr_t CTR_WEAK_T  = 2'd2;
  localparam ctr_t CTR_MAX     = 2'd3;

  // Upper counter bit decides the predicted direction.
  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic [ADDR_W-1:0]          pc,
  output logic [IDX_W-1:0]           idx,
  output logic [ADDR_W-IDX_W-3:0]    tag
);
  localparam int TAG_LSB = IDX_W + 2;

  always_comb begin
    idx = pc[TAG_LSB-1:2];
    tag = pc[ADDR_W-1:TAG_LSB];
  end
endmodule

// File: rtl/btb_ctr_update.sv
module btb_ctr_update
  import btb_pkg::*;
(
  input  logic install,
  input  logic taken,
  input  ctr_t ctr_old,
  output ctr_t ctr_new
);
  always_comb begin
    if (install) begin
      ctr_new = taken ? CTR_WEAK_T : CTR_WEAK_NT;
    end else if (taken) begin
      ctr_new = (ctr_old == CTR_MAX) ? ctr_old : ctr_old + 2'd1;
    end else begin
      ctr_new = (ctr_old == CTR_MIN) ? ctr_old : ctr_old - 2'd1;
    end
  end
endmodule

// File: rtl/btb_entry_store.sv
module btb_entry_store
  import btb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(ENTRIES)-1:0] rd_a_idx,
  output logic                       rd_a_valid,
  output logic [TAG_W-1:0]           rd_a_tag,
  output logic [ADDR_W-1:0]          rd_a_tgt,
  output ctr_t                       rd_a_ctr,
  input  logic [$clog2(ENTRIES)-1:0] rd_b_idx,
  output logic                       rd_b_valid,
  output logic [TAG_W-1:0]           rd_b_tag,
  output ctr_t                       rd_b_ctr,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_install,
  input  logic                       wr_taken,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [ADDR_W-1:0]          wr_tgt,
  input  ctr_t                       wr_ctr
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // Payload needs no reset; the valid flag guards it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ctr_q[wr_idx] <= wr_ctr;
      if (wr_install || wr_taken) begin
        tgt_q[wr_idx] <= wr_tgt;
      end
    end
  end

  always_comb begin
    rd_a_valid = valid_q[rd_a_idx];
    rd_a_tag   = tag_q[rd_a_idx];
    rd_a_tgt   = tgt_q[rd_a_idx];
    rd_a_ctr   = ctr_q[rd_a_idx];
    rd_b_valid = valid_q[rd_b_idx];
    rd_b_tag   = tag_q[rd_b_idx];
    rd_b_ctr   = ctr_q[rd_b_idx];
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (valid_q == '0));

  // R3
  install_ctr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_install) |=>
      (valid_q[$past(wr_idx)] &&
       ctr_q[$past(wr_idx)] == ($past(wr_taken) ? CTR_WEAK_T : CTR_WEAK_NT)));

  // R5
  sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_install && wr_taken && ctr_q[wr_idx] == CTR_MAX) |=>
      (ctr_q[$past(wr_idx)] == CTR_MAX));

  // R6
  sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_install && !wr_taken && ctr_q[wr_idx] == CTR_MIN) |=>
      (ctr_q[$past(wr_idx)] == CTR_MIN));

  // R10
  tgt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_install && !wr_taken) |=>
      (tgt_q[$past(wr_idx)] == $past(tgt_q[wr_idx])));

  // keep the IDX_W derivation visible to readers of the port widths
  initial begin
    if (IDX_W < 1) $display("btb_entry_store: ENTRIES must be at least 2");
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_is_jump,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) lk_split_i (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) up_split_i (
    .pc(upd_pc), .idx(up_idx), .tag(up_tag));

  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [ADDR_W-1:0] a_tgt;
  ctr_t              a_ctr, b_ctr, new_ctr;
  logic              lk_hit, up_hit, eff_taken, install;

  always_comb begin
    lk_hit    = a_valid && (a_tag == lk_tag);
    up_hit    = b_valid && (b_tag == up_tag);
    eff_taken = upd_taken || upd_is_jump;
    install   = !up_hit;
  end

  btb_ctr_update ctr_upd_i (
    .install(install), .taken(eff_taken), .ctr_old(b_ctr), .ctr_new(new_ctr));

  btb_entry_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst(rst),
    .rd_a_idx(lk_idx), .rd_a_valid(a_valid), .rd_a_tag(a_tag),
    .rd_a_tgt(a_tgt), .rd_a_ctr(a_ctr),
    .rd_b_idx(up_idx), .rd_b_valid(b_valid), .rd_b_tag(b_tag), .rd_b_ctr(b_ctr),
    .wr_en(upd_valid), .wr_idx(up_idx), .wr_install(install),
    .wr_taken(eff_taken), .wr_tag(up_tag), .wr_tgt(upd_target), .wr_ctr(new_ctr));

  always_comb begin
    pred_taken  = lk_hit && ctr_says_taken(a_ctr);
    pred_target = pred_taken ? a_tgt : lk_pc + INSN_BYTES;
  end

  // R4
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> (a_valid && a_tag == lk_tag));

  // R9
  jump_counts_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_is_jump && install) |=>
      ($past(up_idx) != up_idx || upd_valid || b_ctr == CTR_WEAK_T));
endmodule

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        pred_taken;
  logic [31:0] pred_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_is_jump = 1'b0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  btb_predictor dut_i (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_target(pred_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_is_jump(upd_is_jump), .upd_taken(upd_taken), .upd_target(upd_target));

  // Reference table built from the requirements
  bit          m_valid [128];
  logic [22:0] m_tag   [128];
  logic [31:0] m_tgt   [128];
  int          m_ctr   [128];

  function automatic bit exp_taken(input logic [31:0] pc);
    int i = int'(pc[8:2]);
    return m_valid[i] && m_tag[i] == pc[31:9] && m_ctr[i] >= 2;
  endfunction

  function automatic logic [31:0] exp_target(input logic [31:0] pc);
    return exp_taken(pc) ? m_tgt[int'(pc[8:2])] : pc + 32'd4;
  endfunction

  task automatic model_update(input logic [31:0] pc, input bit jmp,
                              input bit tk, input logic [31:0] tg);
    int  i   = int'(pc[8:2]);
    bit  t   = tk || jmp;
    if (!(m_valid[i] && m_tag[i] == pc[31:9])) begin
      m_valid[i] = 1'b1;
      m_tag[i]   = pc[31:9];
      m_tgt[i]   = tg;
      m_ctr[i]   = t ? 2 : 1;
    end else begin
      if (t) begin
        m_tgt[i] = tg;
        if (m_ctr[i] < 3) m_ctr[i]++;
      end else if (m_ctr[i] > 0) begin
        m_ctr[i]--;
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] pc);
    bit          et = exp_taken(pc);
    logic [31:0] eg = exp_target(pc);
    n_cmp++;
    if (pred_taken !== et || pred_target !== eg) begin
      n_bad++;
      $display("FAIL %s pc=%h taken=%b target=%h expected taken=%b target=%h",
               req, pc, pred_taken, pred_target, et, eg);
    end
  endtask

  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input bit jmp, input bit tk, input logic [31:0] tg,
                      input string req);
    @(negedge clk);
    lk_pc = lpc; upd_valid = uv; upd_pc = upc;
    upd_is_jump = jmp; upd_taken = tk; upd_target = tg;
    #1;
    check(req, lpc);          // old contents before the edge (R8)
    @(posedge clk);
    #1;
    if (uv) model_update(upc, jmp, tk, tg);
  endtask

  task automatic look(input logic [31:0] lpc, input string req);
    step(lpc, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  localparam logic [31:0] PA = 32'h0000_1040;
  localparam logic [31:0] PB = 32'h0000_3040;  // same index as PA, other tag
  localparam logic [31:0] PC = 32'h0000_1044;
  localparam logic [31:0] PD = 32'h0000_1048;

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: empty table after reset
    look(PA, "R1");
    look(32'hDEAD_BEE0, "R1");
    // R3 taken install; same-cycle lookup sees old state (R8)
    step(PA, 1'b1, PA, 1'b0, 1'b1, 32'h0000_2000, "R8");
    look(PA, "R3");
    // R5: saturate at 3, then one not-taken with a new target (R10)
    repeat (3) step(PA, 1'b1, PA, 1'b0, 1'b1, 32'h0000_2000, "R5");
    step(PA, 1'b1, PA, 1'b0, 1'b0, 32'h0000_5550, "R10");
    look(PA, "R5");
    look(PA, "R10");
    // R6: drive counter to 0 and beyond, then climb back
    repeat (4) step(PA, 1'b1, PA, 1'b0, 1'b0, 32'h0000_6000, "R6");
    step(PA, 1'b1, PA, 1'b0, 1'b1, 32'h0000_2100, "R6");
    look(PA, "R6");
    step(PA, 1'b1, PA, 1'b0, 1'b1, 32'h0000_2200, "R6");
    look(PA, "R6");
    // R7: alias replaces the entry
    step(PB, 1'b1, PB, 1'b0, 1'b1, 32'h0000_7000, "R7");
    look(PA, "R7");
    look(PB, "R7");
    // R9: jump with taken flag low still counts as taken
    step(PC, 1'b1, PC, 1'b1, 1'b0, 32'h0000_0100, "R9");
    look(PC, "R9");
    // R3: not-taken install starts weakly not-taken
    step(PD, 1'b1, PD, 1'b0, 1'b0, 32'h0000_0300, "R3");
    look(PD, "R3");
    step(PD, 1'b1, PD, 1'b0, 1'b1, 32'h0000_0300, "R3");
    look(PD, "R3");
    // R2: low two bits do not affect selection or match
    look(PC | 32'h2, "R2");
    look(PC | 32'h1, "R2");

    // R4: constrained random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      a = {($urandom_range(1) != 0) ? 23'h0000A5 : 23'h00001B,
           7'($urandom_range(3) + 7'd20), 2'($urandom_range(3))};
      b = ($urandom_range(3) == 0) ? a :
          {($urandom_range(1) != 0) ? 23'h0000A5 : 23'h00001B,
           7'($urandom_range(3) + 7'd20), 2'b00};
      step(a, $urandom_range(3) != 0, b, $urandom_range(7) == 0,
           $urandom_range(1) != 0, $urandom, "R4");
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule